// File: doc/BRIEF.md
# Dual-Channel Serial DAC Load Interface

This block is the digital front end of a two-channel digital-to-analog converter. A host shifts an 18-bit word into the block on a serial clock while holding an active-low select. When the select is released, the 16-bit data field goes into the input register of one channel, of both channels, or of neither, as the two address bits choose. A separate active-low, level-sensitive load strobe copies both input registers into the DAC registers that drive the converters. This double buffering lets the two channels change together. A separate active-low clear line sets every register to a preset value. A static scale-select pin picks that preset: zero scale or midscale. The same preset is applied at power-on.

All serial and strobe inputs are asynchronous to the block clock. Each one passes through a two-flop synchroniser before any logic uses it, so the whole block runs in one clock domain. A three-state frame machine tracks the select line. In `FR_IDLE` the bit counter is held at zero. The transition `FR_IDLE -> FR_SHIFT` happens when the select goes low. In `FR_SHIFT` each rising serial clock edge shifts one bit in. When the select rises, the machine takes `FR_SHIFT -> FR_COMMIT` if at least 18 bits have arrived. Otherwise it takes `FR_SHIFT -> FR_IDLE` and the frame is discarded. `FR_COMMIT` lasts one cycle, writes the addressed input register(s), and always returns with `FR_COMMIT -> FR_IDLE`. Each channel also gives a one-cycle update pulse whenever its DAC register value changes.

Top module: `dual_dac_load_if`

## Requirements
- R1: When `por_n` is released, both input registers and both DAC registers hold the preset, and neither update output is high. The preset is 0x0000 when `mid_sel` is 0 and 0x8000 when `mid_sel` is 1.
- R2: A frame is sent MSB first. Each bit is sampled on a rising `ser_clk` edge while `ser_sel_n` is low. Frame bits [17:16] are the address and bits [15:0] are the data. When `ser_sel_n` rises, address 01 writes channel A's input register, 10 writes channel B's, 11 writes both, and 00 writes neither.
- R3: If more than 18 bits arrive, only the last 18 bits before `ser_sel_n` rises are used. A frame of fewer than 18 bits writes no input register.
- R4: `ser_clk` edges while `ser_sel_n` is high shift nothing and write no input register.
- R5: While `load_n` is low, both DAC registers take their input register values on every cycle. While `load_n` is high, the DAC registers keep their values. An input register write alone does not change a DAC output. `ser_sel_n` has no effect on the load.
- R6: While `clr_n` is low, all four registers are set to the preset chosen by `mid_sel`. This takes priority over the load strobe and over an input register write.
- R7: If a load and an input register write fall in the same cycle, the DAC register takes the input register value from before the write. The write still lands. If `load_n` stays low, the new value reaches the DAC register on the next cycle.
- R8: `upd_a` and `upd_b` are each high for exactly one cycle for every cycle in which that channel's DAC register changes value. Reloading an equal value gives no pulse.
- R9: Every level on `ser_clk`, `ser_din`, `ser_sel_n`, `load_n` and `clr_n` must last at least three `clk` cycles to be seen. `mid_sel` changes only while `por_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ser_clk | input | 1 | Serial bit clock, rising edge samples data |
| ser_din | input | 1 | Serial data |
| ser_sel_n | input | 1 | Frame select, active low; rising edge commits the frame |
| load_n | input | 1 | Level-sensitive load strobe, active low |
| clr_n | input | 1 | Clear to preset, active low |
| mid_sel | input | 1 | Preset select: 0 zero scale, 1 midscale |
| dac_a | output | DATA_W | Channel A DAC register |
| dac_b | output | DATA_W | Channel B DAC register |
| upd_a | output | 1 | Channel A change pulse |
| upd_b | output | 1 | Channel B change pulse |

## Verification
Frames are sent with every address value. This separates single-channel writes, dual writes and the no-op code. Over-long frames with leading junk bits and 17-bit frames show whether only the trailing 18 bits count and whether short frames are dropped. Bursts of `ser_clk` edges with the select high check that idle clocks are ignored. Holding the load strobe low while a frame commits separates the transparent load from a one-shot copy. Clears under both preset choices, rewrites of an equal value, and a fixed-seed random mix of writes, loads and clears are each compared with a bench model of the registers and of the expected number of update pulses.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned CHAN_N = 2;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SHIFT  = 2'd1,
        FR_COMMIT = 2'd2
    } frame_state_e;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q[0] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_q[g] <= RST_VAL;
            end else begin
                stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_load_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              csn_s,
    output logic [CHAN_N-1:0] wr_en,
    output logic [DATA_W-1:0] wr_data
);

    localparam int unsigned FRAME_W = ADDR_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    frame_state_e         state_q;
    frame_state_e         state_d;
    logic [FRAME_W-1:0]   shreg_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 sclk_d;
    logic                 sclk_rise;
    logic                 frame_full;
    logic                 shift_en;
    logic                 cnt_clr;

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign frame_full = (cnt_q == CNT_W'(FRAME_W));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (!csn_s) state_d = FR_SHIFT;
            end
            FR_SHIFT: begin
                if (csn_s) state_d = frame_full ? FR_COMMIT : FR_IDLE;
            end
            FR_COMMIT: begin
                state_d = FR_IDLE;
            end
            default: begin
                state_d = FR_IDLE;
            end
        endcase
    end

    // outputs per state
    always_comb begin
        shift_en = 1'b0;
        cnt_clr  = 1'b0;
        wr_en    = '0;
        unique case (state_q)
            FR_IDLE: begin
                cnt_clr = 1'b1;
            end
            FR_SHIFT: begin
                shift_en = sclk_rise & ~csn_s;
            end
            FR_COMMIT: begin
                // address bit 0 selects channel A, bit 1 channel B
                wr_en = shreg_q[FRAME_W-1 -: ADDR_W];
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

    assign wr_data = shreg_q[DATA_W-1:0];

    // shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (shift_en) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s};
            end
            if (cnt_clr) begin
                cnt_q <= '0;
            end else if (shift_en && !frame_full) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] preset,
    input  logic              clr,
    input  logic              load,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] dac_q,
    output logic              upd
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= preset;
            dac_q <= preset;
            upd   <= 1'b0;
        end else if (clr) begin
            in_q  <= preset;
            dac_q <= preset;
            upd   <= (dac_q != preset);
        end else begin
            upd <= 1'b0;
            if (load) begin
                dac_q <= in_q;
                upd   <= (dac_q != in_q);
            end
            if (wr) begin
                in_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dual_dac_load_if.sv
module dual_dac_load_if
    import dac_load_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_sel_n,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              mid_sel,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic              upd_a,
    output logic              upd_b
);

    localparam int unsigned SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    logic              sclk_s;
    logic              sdi_s;
    logic              csn_s;
    logic              load_act;
    logic              clr_act;
    logic [DATA_W-1:0] preset;
    logic [CHAN_N-1:0] wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] in_q   [CHAN_N];
    logic [DATA_W-1:0] dac_q  [CHAN_N];
    logic [CHAN_N-1:0] upd;
    logic [DATA_W-1:0] in_a_q;
    logic [DATA_W-1:0] in_b_q;

    assign raw_in = {clr_n, load_n, ser_sel_n, ser_din, ser_clk};

    dac_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11100)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign sclk_s   = syn_in[0];
    assign sdi_s    = syn_in[1];
    assign csn_s    = syn_in[2];
    assign load_act = ~syn_in[3];
    assign clr_act  = ~syn_in[4];

    assign preset = {mid_sel, {(DATA_W-1){1'b0}}};

    dac_frame_fsm #(
        .DATA_W (DATA_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (por_n),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .csn_s   (csn_s),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    for (genvar ch = 0; ch < CHAN_N; ch++) begin : g_chan
        dac_chan_regs #(
            .DATA_W (DATA_W)
        ) u_regs (
            .clk     (clk),
            .rst_n   (por_n),
            .preset  (preset),
            .clr     (clr_act),
            .load    (load_act),
            .wr      (wr_en[ch]),
            .wr_data (wr_data),
            .in_q    (in_q[ch]),
            .dac_q   (dac_q[ch]),
            .upd     (upd[ch])
        );
    end

    assign in_a_q = in_q[0];
    assign in_b_q = in_q[1];
    assign dac_a  = dac_q[0];
    assign dac_b  = dac_q[1];
    assign upd_a  = upd[0];
    assign upd_b  = upd[1];

endmodule

// File: rtl/dac_load_chk.sv
module dac_load_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              mid_sel,
    input logic              clr_act,
    input logic              load_act,
    input logic [1:0]        wr_en,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [DATA_W-1:0] dac_a,
    input logic [DATA_W-1:0] dac_b,
    input logic              upd_a,
    input logic              upd_b
);

    logic [DATA_W-1:0] pre;
    assign pre = {mid_sel, {(DATA_W-1){1'b0}}};

    a_r1_reset_preset: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (dac_a == pre && dac_b == pre && in_a == pre && in_b == pre && !upd_a && !upd_b));

    a_r6_clear_preset: assert property (@(posedge clk) disable iff (!por_n)
        clr_act |=> (dac_a == pre && dac_b == pre && in_a == pre && in_b == pre));

    a_r5_r7_load_copies_old: assert property (@(posedge clk) disable iff (!por_n)
        (load_act && !clr_act) |=> (dac_a == $past(in_a) && dac_b == $past(in_b)));

    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!por_n)
        (!load_act && !clr_act) |=> ($stable(dac_a) && $stable(dac_b)));

    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en == 2'b00 && !clr_act) |=> ($stable(in_a) && $stable(in_b)));

    a_r8_pulse_a: assert property (@(posedge clk) disable iff (!por_n)
        upd_a == (dac_a != $past(dac_a)));

    a_r8_pulse_b: assert property (@(posedge clk) disable iff (!por_n)
        upd_b == (dac_b != $past(dac_b)));

endmodule

bind dual_dac_load_if dac_load_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .por_n    (por_n),
    .mid_sel  (mid_sel),
    .clr_act  (clr_act),
    .load_act (load_act),
    .wr_en    (wr_en),
    .in_a     (in_a_q),
    .in_b     (in_b_q),
    .dac_a    (dac_a),
    .dac_b    (dac_b),
    .upd_a    (upd_a),
    .upd_b    (upd_b)
);

// File: tb/dual_dac_load_if_tb_top.sv
`timescale 1ns/1ps
module dual_dac_load_if_tb_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_sel_n = 1'b1;
    logic        load_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        mid_sel = 1'b0;
    logic [15:0] dac_a;
    logic [15:0] dac_b;
    logic        upd_a;
    logic        upd_b;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_in  [2];
    logic [15:0] exp_dac [2];
    int          exp_cnt [2];
    int          seen_a = 0;
    int          seen_b = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    dual_dac_load_if dut_i (
        .clk       (clk),
        .por_n     (por_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_sel_n (ser_sel_n),
        .load_n    (load_n),
        .clr_n     (clr_n),
        .mid_sel   (mid_sel),
        .dac_a     (dac_a),
        .dac_b     (dac_b),
        .upd_a     (upd_a),
        .upd_b     (upd_b)
    );

    always @(negedge clk) begin
        if (por_n) begin
            if (upd_a) seen_a++;
            if (upd_b) seen_b++;
        end
    end

    function automatic logic [15:0] preset_of(input logic m);
        return {m, 15'h0000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " dac_a"}, int'(dac_a), int'(exp_dac[0]));
        chk({req, " dac_b"}, int'(dac_b), int'(exp_dac[1]));
        chk({req, " upd_a count"}, seen_a, exp_cnt[0]);
        chk({req, " upd_b count"}, seen_b, exp_cnt[1]);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_on(input logic m);
        @(negedge clk);
        por_n = 1'b0;
        mid_sel = m;
        wait_n(4);
        seen_a = 0;
        seen_b = 0;
        por_n = 1'b1;
        wait_n(4);
        for (int c = 0; c < 2; c++) begin
            exp_in[c]  = preset_of(m);
            exp_dac[c] = preset_of(m);
            exp_cnt[c] = 0;
        end
    endtask

    task automatic model_copy();
        for (int c = 0; c < 2; c++) begin
            if (exp_dac[c] != exp_in[c]) exp_cnt[c]++;
            exp_dac[c] = exp_in[c];
        end
    endtask

    task automatic do_load();
        @(negedge clk);
        load_n = 1'b0;
        wait_n(5);
        load_n = 1'b1;
        wait_n(5);
        model_copy();
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0;
        wait_n(5);
        clr_n = 1'b1;
        wait_n(5);
        for (int c = 0; c < 2; c++) begin
            if (exp_dac[c] != preset_of(mid_sel)) exp_cnt[c]++;
            exp_dac[c] = preset_of(mid_sel);
            exp_in[c]  = preset_of(mid_sel);
        end
    endtask

    // drives n bits MSB first, bits taken from the low n bits of val
    task automatic send_bits(input logic [31:0] val, input int n);
        @(negedge clk);
        ser_sel_n = 1'b0;
        wait_n(3);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = val[i];
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
            ser_clk = 1'b0;
        end
        wait_n(3);
        ser_sel_n = 1'b1;
        wait_n(8);
        if (n >= 18) begin
            if (val[16]) exp_in[0] = val[15:0];
            if (val[17]) exp_in[1] = val[15:0];
        end
    endtask

    task automatic send_frame(input logic [1:0] addr, input logic [15:0] data);
        send_bits({14'h0, addr, data}, 18);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            exp_in[c] = '0; exp_dac[c] = '0; exp_cnt[c] = 0;
        end

        // R1: zero-scale power-on
        power_on(1'b0);
        chk_all("R1 power-on zero scale");
        do_load();
        chk_all("R1 input regs preset after power-on");

        // R2 / R5: single-channel write does not reach the output without load
        send_frame(2'b01, 16'hA5A5);
        chk_all("R5 write without load leaves outputs");
        do_load();
        chk_all("R2 addr 01 writes channel A");

        send_frame(2'b10, 16'h1234);
        send_frame(2'b11, 16'hBEEF);
        send_frame(2'b00, 16'hFFFF);
        do_load();
        chk_all("R2 addr 10/11/00 decode");

        // R3: long frame keeps trailing 18 bits, short frame dropped
        send_bits({10'h0, 4'hF, 2'b01, 16'h0F0F}, 22);
        send_bits({15'h0, 1'b1, 16'h7777}, 17);
        do_load();
        chk_all("R3 trailing 18 bits and short frame");

        // R4: serial clocks with select high
        @(negedge clk);
        ser_din = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_n(3); ser_clk = 1'b1; wait_n(3); ser_clk = 1'b0;
        end
        ser_din = 1'b0;
        wait_n(8);
        do_load();
        chk_all("R4 clocks ignored while deselected");

        // R8: reload of an equal value gives no pulse
        send_frame(2'b01, 16'h0F0F);
        do_load();
        chk_all("R8 equal value no pulse");

        // R5 / R7: load held low, write lands and is copied next cycle
        @(negedge clk);
        load_n = 1'b0;
        wait_n(5);
        model_copy();
        send_frame(2'b10, 16'h5A5A);
        wait_n(4);
        model_copy();
        chk_all("R7 transparent load follows new write");
        @(negedge clk);
        load_n = 1'b1;
        wait_n(5);

        // R6: clear to zero scale, then clear together with load
        do_clear();
        chk_all("R6 clear zero scale");
        send_frame(2'b11, 16'hC3C3);
        @(negedge clk);
        clr_n = 1'b0;
        load_n = 1'b0;
        wait_n(5);
        clr_n = 1'b1;
        load_n = 1'b1;
        wait_n(6);
        exp_in[0] = 16'h0000; exp_in[1] = 16'h0000;
        chk_all("R6 clear beats load");
        do_load();
        chk_all("R6 clear also empties input regs");

        // R1 / R6 midscale
        power_on(1'b1);
        chk_all("R1 power-on midscale");
        send_frame(2'b11, 16'h0001);
        do_load();
        do_clear();
        chk_all("R6 clear midscale");

        // random mix, R9 timing respected by all tasks
        for (int k = 0; k < 120; k++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                send_frame(2'($urandom_range(0, 3)), 16'($urandom_range(0, 3) == 0 ? 16'h0F0F : $urandom));
            end else if (op < 6) begin
                send_bits($urandom, 17 + int'($urandom_range(0, 5)));
            end else if (op < 9) begin
                do_load();
            end else begin
                do_clear();
            end
            if (k % 10 == 9) chk_all("R2 R3 R5 R6 R8 random mix");
        end
        do_load();
        chk_all("R5 R9 random final");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule